// File: doc/BRIEF.md
# Banked Work-Group Scratchpad

This block is the on-chip scratch RAM that the lanes of one work-group share. The RAM is split into parallel banks. A single vector request holds up to 32 lane accesses, and each access is a read, a write or an atomic read-modify-write on one 32-bit word. When every active lane maps to its own bank, the whole request finishes in one pass. When lanes collide on a bank, the block breaks the request into as many serial passes as the worst bank needs, and it returns the per-lane results only after every lane has been served.

Atomic operations run inside the RAM banks themselves. Every atomic returns the word as it stood before the operation. Every lane address is checked against the window that the work-group owns. The window is given by a base word and a size in words, and the size is capped at half of the total capacity. A lane that falls outside the window is dropped, and its error bit is set.

Both the request side and the response side are valid/ready streams. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block holds no request. After a request is accepted, the block takes no new request until its response has been taken. The response is offered with `rsp_valid` and stays stable until `rsp_ready` is seen high. The window inputs are plain inputs and are sampled when a request is accepted.

Top module: `wg_scratchpad`

## Requirements
- R1: `req_ready` is high after reset and whenever no request is held. It drops on the edge that accepts a request and stays low until the response has been taken.
- R2: A request whose active lanes all map to different banks produces `rsp_valid` one clock after the accepting edge, with `rsp_done` equal to the active in-window lanes.
- R3: The bank is word address bits [4:0] and the row is bits [9:5]. In each pass, each bank serves the row of its lowest-numbered pending lane. The number of clock edges from acceptance to `rsp_valid` therefore equals the largest number of lanes that any single bank must serve in turn.
- R4: A pending read lane shares the pass of its bank's granted lane when both are reads of the same row (broadcast). It then receives the same word.
- R5: Writes and atomics that target one word in one request are applied one per pass, in ascending lane order. The final word is the result of the highest lane, and each lane returns the word as it stood just before its own access.
- R6: Operation codes on `req_op` are: 0 read, 1 write, 8 add, 9 unsigned min, 10 unsigned max, 11 and, 12 or, 13 xor, 14 swap. Any other code acts as a read. Every served lane returns the word value held before its pass.
- R7: A lane whose address lies outside [`wg_base`, `wg_base`+size) is not performed and leaves memory unchanged. It has its `rsp_err` bit set, its `rsp_done` bit clear and its data zero. A request with no in-window lane responds on the edge after acceptance.
- R8: A `wg_size` above 512 words (half of the 1024-word capacity) is treated as 512.
- R9: Lanes with a clear `req_mask` bit are not performed. They respond with done clear, error clear and data zero.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_done` and `rsp_err` hold their values.
- R11: After reset, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wg_base | input | 10 | First word of the work-group window |
| wg_size | input | 11 | Window size in words, capped at 512 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_mask | input | 32 | Active lanes |
| req_op | input | 32x4 | Operation code per lane |
| req_addr | input | 32x10 | Word address per lane |
| req_wdata | input | 32x32 | Write or atomic operand per lane |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_done | output | 32 | Lanes that were served |
| rsp_err | output | 32 | Lanes dropped by the window check |
| rsp_data | output | 32x32 | Pre-access word per served lane |

## Verification
Read requests are tried with lane strides of 1, 2, 4, 8, 16, 32 and 0 (all lanes on one word). This separates conflict-free timing, conflicts between 2, 4, 8 and 16 rows, the worst single-bank case and the broadcast path, because each pattern gives a different pass count. Chains of writes and of every atomic code on a single word show whether lane order and pre-operation return values are correct. Windows with lanes just outside each edge, an oversized size, a request with no in-window lane, sparse masks and a stalled consumer cover the error path, the size cap and back-pressure.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam logic [3:0] OP_RD   = 4'd0;
  localparam logic [3:0] OP_WR   = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd8;
  localparam logic [3:0] OP_UMIN = 4'd9;
  localparam logic [3:0] OP_UMAX = 4'd10;
  localparam logic [3:0] OP_AND  = 4'd11;
  localparam logic [3:0] OP_OR   = 4'd12;
  localparam logic [3:0] OP_XOR  = 4'd13;
  localparam logic [3:0] OP_SWAP = 4'd14;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} scr_state_e;

  function automatic logic op_is_amo(input logic [3:0] op);
    return (op >= OP_ADD) && (op <= OP_SWAP);
  endfunction

  function automatic logic op_is_read(input logic [3:0] op);
    return (op != OP_WR) && !op_is_amo(op);
  endfunction

  function automatic logic [31:0] amo_apply(input logic [3:0] op,
                                            input logic [31:0] cur,
                                            input logic [31:0] arg);
    case (op)
      OP_ADD:  return cur + arg;
      OP_UMIN: return (arg < cur) ? arg : cur;
      OP_UMAX: return (arg > cur) ? arg : cur;
      OP_AND:  return cur & arg;
      OP_OR:   return cur | arg;
      OP_XOR:  return cur ^ arg;
      default: return arg;
    endcase
  endfunction
endpackage

// File: rtl/scr_window_chk.sv
module scr_window_chk #(
  parameter int LANES = 32,
  parameter int AW    = 10,
  parameter int HALF  = 512
) (
  input  logic [AW-1:0]             base,
  input  logic [AW:0]               size,
  input  logic [LANES-1:0][AW-1:0]  addr,
  output logic [LANES-1:0]          inwin
);
  logic [AW:0] eff;

  always_comb begin
    eff = (size > (AW+1)'(HALF)) ? (AW+1)'(HALF) : size;
    for (int l = 0; l < LANES; l++) begin
      logic [AW:0] off;
      off = {1'b0, addr[l]} - {1'b0, base};
      inwin[l] = (addr[l] >= base) && (off < eff);
    end
  end
endmodule

// File: rtl/scr_bank_arb.sv
module scr_bank_arb #(
  parameter int LANES   = 32,
  parameter int BW      = 5,
  parameter int RW      = 5,
  parameter int LW      = 5,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]          pend,
  input  logic [LANES-1:0][BW-1:0]  lbank,
  input  logic [LANES-1:0][RW-1:0]  lrow,
  input  logic [LANES-1:0]          lread,
  output logic [LANES-1:0]          grant,
  output logic [LW-1:0]             lead,
  output logic                      active
);
  logic [LANES-1:0] hit;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      hit[l] = pend[l] && (lbank[l] == BW'(BANK_ID));
    lead   = '0;
    active = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && !active) begin
        lead   = LW'(l);
        active = 1'b1;
      end
    end
    for (int l = 0; l < LANES; l++)
      grant[l] = hit[l] && ((LW'(l) == lead) ||
                 (lread[lead] && lread[l] && (lrow[l] == lrow[lead])));
  end
endmodule

// File: rtl/scr_bank.sv
module scr_bank #(
  parameter int ROWS = 32,
  parameter int RW   = 5,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic [RW-1:0] row,
  input  logic [3:0]    op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  import scr_pkg::*;

  logic [DW-1:0] mem [ROWS];

  assign rdata = mem[row];

  always_ff @(posedge clk) begin
    if (en) begin
      if (op == OP_WR)
        mem[row] <= wdata;
      else if (op_is_amo(op))
        mem[row] <= amo_apply(op, mem[row], wdata);
    end
  end
endmodule

// File: rtl/wg_scratchpad.sv
module wg_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 32,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW,
  localparam int LW   = $clog2(LANES),
  localparam int HALF = (BANKS * ROWS) / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             wg_base,
  input  logic [AW:0]               wg_size,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [LANES-1:0]          req_mask,
  input  logic [LANES-1:0][3:0]     req_op,
  input  logic [LANES-1:0][AW-1:0]  req_addr,
  input  logic [LANES-1:0][DW-1:0]  req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [LANES-1:0]          rsp_done,
  output logic [LANES-1:0]          rsp_err,
  output logic [LANES-1:0][DW-1:0]  rsp_data
);
  import scr_pkg::*;

  scr_state_e state;
  logic [LANES-1:0]          q_mask, pend, done_q, err_q;
  logic [LANES-1:0][3:0]     q_op;
  logic [LANES-1:0][AW-1:0]  q_addr;
  logic [LANES-1:0][DW-1:0]  q_wd, data_q;
  logic [LANES-1:0]          inwin, grant, lread;
  logic [LANES-1:0][BW-1:0]  lbank;
  logic [LANES-1:0][RW-1:0]  lrow;
  logic [LANES-1:0][DW-1:0]  lane_rd;
  logic [BANKS-1:0][LANES-1:0] bgrant;
  logic [BANKS-1:0][LW-1:0]  blead;
  logic [BANKS-1:0]          bact;
  logic [BANKS-1:0][DW-1:0]  brd;
  logic                      accept;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_data  = data_q;

  scr_window_chk #(.LANES(LANES), .AW(AW), .HALF(HALF)) win_i (
    .base(wg_base), .size(wg_size), .addr(req_addr), .inwin(inwin)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lbank[l]   = q_addr[l][BW-1:0];
      lrow[l]    = q_addr[l][AW-1:BW];
      lread[l]   = op_is_read(q_op[l]);
      lane_rd[l] = brd[lbank[l]];
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scr_bank_arb #(.LANES(LANES), .BW(BW), .RW(RW), .LW(LW), .BANK_ID(b)) arb_i (
      .pend(pend), .lbank(lbank), .lrow(lrow), .lread(lread),
      .grant(bgrant[b]), .lead(blead[b]), .active(bact[b])
    );
    scr_bank #(.ROWS(ROWS), .RW(RW), .DW(DW)) ram_i (
      .clk(clk),
      .en(bact[b] && (state == ST_BUSY)),
      .row(lrow[blead[b]]),
      .op(q_op[blead[b]]),
      .wdata(q_wd[blead[b]]),
      .rdata(brd[b])
    );

    // R5
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BUSY) |-> ($countones(bgrant[b] & ~lread) <= 1));
  end

  always_comb begin
    grant = '0;
    for (int b = 0; b < BANKS; b++) grant |= bgrant[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      q_mask <= '0;
      pend   <= '0;
      done_q <= '0;
      err_q  <= '0;
      q_op   <= '0;
      q_addr <= '0;
      q_wd   <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          q_mask <= req_mask;
          q_op   <= req_op;
          q_addr <= req_addr;
          q_wd   <= req_wdata;
          pend   <= req_mask & inwin;
          err_q  <= req_mask & ~inwin;
          done_q <= '0;
          data_q <= '0;
          state  <= (|(req_mask & inwin)) ? ST_BUSY : ST_RESP;
        end
        ST_BUSY: begin
          pend   <= pend & ~grant;
          done_q <= done_q | grant;
          for (int l = 0; l < LANES; l++)
            if (grant[l]) data_q[l] <= lane_rd[l];
          if ((pend & ~grant) == '0) state <= ST_RESP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R3
  pass_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |=> (((pend & ~$past(pend)) == '0) && (pend != $past(pend))));
  // R7
  err_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_done & rsp_err) == '0));
  // R9
  done_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_done | rsp_err) & ~q_mask) == '0));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                   $stable(rsp_done) && $stable(rsp_err)));
endmodule

// File: tb/wg_scratchpad_tb_top.sv
module wg_scratchpad_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [9:0]         wg_base;
  logic [10:0]        wg_size;
  logic               req_valid, req_ready, rsp_valid, rsp_ready;
  logic [31:0]        t_mask, rsp_done, rsp_err;
  logic [31:0][3:0]   t_op;
  logic [31:0][9:0]   t_addr;
  logic [31:0][31:0]  t_wd, rsp_data;

  int checks = 0;
  int errors = 0;

  wg_scratchpad dut_i (
    .clk(clk), .rst_n(rst_n), .wg_base(wg_base), .wg_size(wg_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_mask(t_mask),
    .req_op(t_op), .req_addr(t_addr), .req_wdata(t_wd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  localparam int NV = 7;
  localparam int TV_STRIDE [NV] = '{1, 2, 4, 8, 16, 32, 0};
  localparam int TV_LANES  [NV] = '{32, 32, 32, 32, 32, 16, 32};
  localparam int TV_PASS   [NV] = '{1, 2, 4, 8, 16, 16, 1};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    t_mask = '0; t_op = '0; t_addr = '0; t_wd = '0;
  endtask

  task automatic lane(input int l, input logic [3:0] op, input int a, input logic [31:0] d);
    t_mask[l] = 1'b1; t_op[l] = op; t_addr[l] = 10'(a); t_wd[l] = d;
  endtask

  task automatic run(output int n);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int bad;
    req_valid = 1'b0; rsp_ready = 1'b0; wg_base = '0; wg_size = 11'd512;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R1 reset state
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);

    // R2 preload: word a holds a*3+7, stride-1 writes, one pass each
    for (int k = 0; k < 16; k++) begin
      clr();
      for (int l = 0; l < 32; l++) lane(l, 4'd1, k*32 + l, 32'(((k*32 + l) * 3) + 7));
      run(n);
      chk(n == 1, "R2 conflict-free write passes", n, 1);
      take();
    end

    // R3 R4 stride table
    for (int v = 0; v < NV; v++) begin
      clr();
      for (int l = 0; l < TV_LANES[v]; l++) lane(l, 4'd0, l * TV_STRIDE[v], 0);
      run(n);
      chk(n == TV_PASS[v], "R3 pass count", n, TV_PASS[v]);
      bad = 0;
      for (int l = 0; l < TV_LANES[v]; l++)
        if (rsp_data[l] != 32'(l * TV_STRIDE[v] * 3 + 7)) bad++;
      chk(bad == 0, "R4 read data per lane", bad, 0);
      chk(rsp_done == t_mask, "R2 done mask", rsp_done, t_mask);
      take();
    end

    // R5 four writes to one word
    clr();
    for (int l = 0; l < 4; l++) lane(l, 4'd1, 100, 32'(10 + l));
    run(n);
    chk(n == 4, "R5 same-word writes serialize", n, 4);
    chk(rsp_data[0] == 32'd307, "R5 lane0 pre-value", rsp_data[0], 307);
    chk(rsp_data[3] == 32'd12, "R5 lane3 pre-value", rsp_data[3], 12);
    take();
    clr(); lane(0, 4'd0, 100, 0); run(n);
    chk(rsp_data[0] == 32'd13, "R5 highest lane wins", rsp_data[0], 13);
    take();

    // R6 atomic chain on word 200 (initial 607)
    clr();
    lane(0, 4'd8, 200, 32'd5);
    lane(1, 4'd9, 200, 32'd100);
    lane(2, 4'd10, 200, 32'd300);
    lane(3, 4'd11, 200, 32'hFC);
    lane(4, 4'd12, 200, 32'h100);
    lane(5, 4'd13, 200, 32'hFF);
    lane(6, 4'd14, 200, 32'h55);
    run(n);
    chk(n == 7, "R6 atomic passes", n, 7);
    chk(rsp_data[0] == 32'd607, "R6 add return", rsp_data[0], 607);
    chk(rsp_data[1] == 32'd612, "R6 umin return", rsp_data[1], 612);
    chk(rsp_data[2] == 32'd100, "R6 umax return", rsp_data[2], 100);
    chk(rsp_data[3] == 32'd300, "R6 and return", rsp_data[3], 300);
    chk(rsp_data[4] == 32'h2C, "R6 or return", rsp_data[4], 32'h2C);
    chk(rsp_data[5] == 32'h12C, "R6 xor return", rsp_data[5], 32'h12C);
    chk(rsp_data[6] == 32'h1D3, "R6 swap return", rsp_data[6], 32'h1D3);
    take();
    clr(); lane(0, 4'd0, 200, 0); run(n);
    chk(rsp_data[0] == 32'h55, "R6 final word", rsp_data[0], 32'h55);
    take();

    // R7 window edges
    wg_base = 10'd64; wg_size = 11'd32;
    clr();
    lane(0, 4'd1, 60, 32'hAAAA);
    lane(1, 4'd1, 64, 32'hAAAA);
    lane(2, 4'd1, 95, 32'hAAAA);
    lane(3, 4'd1, 96, 32'hAAAA);
    run(n);
    chk(n == 1, "R7 window passes", n, 1);
    chk(rsp_err == 32'h9, "R7 error mask", rsp_err, 32'h9);
    chk(rsp_done == 32'h6, "R7 done mask", rsp_done, 32'h6);
    chk(rsp_data[0] == 32'd0, "R7 errored data zero", rsp_data[0], 0);
    take();
    clr(); lane(0, 4'd1, 10, 32'hBEEF);
    run(n);
    chk(n == 0, "R7 no in-window lane responds at once", n, 0);
    take();
    wg_base = 10'd0; wg_size = 11'd512;
    clr();
    lane(0, 4'd0, 60, 0); lane(1, 4'd0, 64, 0); lane(2, 4'd0, 95, 0); lane(3, 4'd0, 96, 0);
    lane(4, 4'd0, 10, 0);
    run(n);
    chk(rsp_data[0] == 32'd187, "R7 addr 60 untouched", rsp_data[0], 187);
    chk(rsp_data[1] == 32'hAAAA, "R7 addr 64 written", rsp_data[1], 32'hAAAA);
    chk(rsp_data[2] == 32'hAAAA, "R7 addr 95 written", rsp_data[2], 32'hAAAA);
    chk(rsp_data[3] == 32'd295, "R7 addr 96 untouched", rsp_data[3], 295);
    chk(rsp_data[4] == 32'd37, "R7 addr 10 untouched", rsp_data[4], 37);
    take();

    // R8 oversized window capped at 512
    wg_size = 11'd1023;
    clr(); lane(0, 4'd1, 600, 32'h1); lane(1, 4'd0, 511, 0);
    run(n);
    chk(rsp_err == 32'h1, "R8 addr 600 rejected", rsp_err, 32'h1);
    chk(rsp_data[1] == 32'd1540, "R8 addr 511 served", rsp_data[1], 1540);
    take();
    wg_size = 11'd512;

    // R9 sparse mask
    clr(); lane(5, 4'd0, 5, 0);
    t_op[4] = 4'd1; t_addr[4] = 10'd6; t_wd[4] = 32'hDEAD;
    run(n);
    chk(rsp_done == 32'h20, "R9 only active lane done", rsp_done, 32'h20);
    chk(rsp_data[4] == 32'd0, "R9 masked lane data", rsp_data[4], 0);
    chk(rsp_data[5] == 32'd22, "R9 active lane data", rsp_data[5], 22);
    take();
    clr(); lane(0, 4'd0, 6, 0); run(n);
    chk(rsp_data[0] == 32'd25, "R9 masked write not done", rsp_data[0], 25);
    take();

    // R10 / R1 stalled consumer
    clr(); lane(0, 4'd0, 7, 0); run(n);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R10 rsp_valid held", rsp_valid, 1);
    chk(rsp_data[0] == 32'd28, "R10 data held", rsp_data[0], 28);
    chk(req_ready == 1'b0, "R1 no accept while response pending", req_ready, 0);
    take();
    chk(req_ready == 1'b1, "R1 ready after response taken", req_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule